// File: doc/BRIEF.md
# Programmable Logic Register Macrocell

This block is one cell of a small programmable logic device. The product-term array sits outside the cell. The cell receives two groups of product terms and ORs a configurable number of each group into two sum terms. Sum term A feeds a single flip-flop, which can work as a D or a T flip-flop. Sum term B can drive the pin directly, bypassing the flip-flop. The register value always returns to the array on a feedback line, whatever the pin shows. This lets the register stay buried while the pin carries combinational logic or is used as an input.

The register advances on a "clock event". A per-cell mux picks the source of that event: either a clock product term or a dedicated clock pin. Both sources are sampled by the system clock `clk`, and a rising edge of the selected source fires the register. Four other controls act on the register:
- an asynchronous reset product term, which clears it;
- a synchronous preset shared by all cells, which sets it at a clock event;
- a preload port, which lets a test controller force a value into it;
- the global reset `rst_n`, which models power-up clearing.

Pin drive is governed by an output-enable product term.

The configuration word is loaded serially while `prog_en` is high. The word holds four fields: the D/T select, the clock-source select, the pin-source select and the product-term count. The loader is a three-state machine:
- `CFG_RUN`: normal operation.
- `CFG_SHIFT`: bits are being shifted in.
- `CFG_COMMIT`: the shifted word becomes active.

Its transitions are:
- RUN→SHIFT when `prog_en` is high.
- SHIFT→SHIFT while `prog_en` stays high.
- SHIFT→COMMIT when `prog_en` is low.
- COMMIT→RUN unconditionally.

Top module: `pld_macrocell`

## Requirements
- R1: While `rst_n` is low, the register is cleared and the active configuration becomes all zeros. All zeros means D mode, clock product term, registered pin and four product terms.
- R2: Each sum term is the OR of product terms 0 to N-1 of its group, with N = 4 + code. The code is held in configuration bits [5:3], and codes 4 to 7 all give N = 8.
- R3: In D mode (configuration bit 0 = 0), a clock event loads sum term A into the register.
- R4: In T mode (configuration bit 0 = 1), a clock event loads the register XOR sum term A.
- R5: Configuration bit 1 picks the clock source: 0 selects `clk_pt` and 1 selects `clk_pin`. The clock event occurs at the first `clk` rising edge that samples the selected source high after it was low. Edges on the unselected source have no effect.
- R6: `ar_pt` high clears the register at once and holds it at 0. It wins over preset and preload.
- R7: `sync_preset` high at a clock event loads 1, overriding the D and T logic.
- R8: `preload_en` sampled high at a `clk` rising edge loads `preload_val`. This happens with or without a clock event, and preload wins over preset.
- R9: `fb` always equals the register value, whichever source drives the pin.
- R10: Configuration bit 2 picks the pin source: 1 makes `pad_data` equal to sum term B, and 0 makes it equal to the register.
- R11: `pad_en` follows `oe_pt`. When it is low, the pin is released.
- R12: While `prog_en` is high, each `clk` rising edge shifts `cfg_sdi` in, least significant bit first, and the last six bits are kept. The new configuration takes effect on the second rising edge after `prog_en` is sampled low, and not before.
- R13: With no clock event, no preload and no reset, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all sources |
| rst_n | input | 1 | Global active-low reset (power-up clear) |
| prog_en | input | 1 | Serial configuration shift enable |
| cfg_sdi | input | 1 | Serial configuration data, least significant bit first |
| pt_a | input | N_PT | Product terms for sum term A (register data) |
| pt_b | input | N_PT | Product terms for sum term B (combinational pin path) |
| clk_pt | input | 1 | Cell clock product term |
| clk_pin | input | 1 | Dedicated clock pin |
| ar_pt | input | 1 | Asynchronous reset product term |
| oe_pt | input | 1 | Output enable product term |
| sync_preset | input | 1 | Shared synchronous preset |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | 1 | Test preload value |
| fb | output | 1 | Register feedback into the array |
| pad_data | output | 1 | Value presented to the pin |
| pad_en | output | 1 | Pin drive enable |

## Verification
The results fall due at different times:
- `pad_data` in combinational mode, `pad_en`, and the clearing by `ar_pt` are due in the same cycle as their stimulus.
- A clock event, preset or preload changes `fb` at the first `clk` rising edge that samples the cause.
- A new configuration becomes visible only after the second rising edge that follows `prog_en` falling.

The bench changes inputs 1 ns after a rising edge and compares outputs at the falling edge. A bench model steps forward once per rising edge, so every comparison lines up with the edge that made the result due. Directed steps exercise the term-count limits, source selection, the three-way priority between reset, preload and preset, and the commit delay. Seeded random epochs, each with a freshly loaded configuration, cover the remaining combinations.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int CODE_W = 3;

    // Bit 0 is t_mode, bit 1 clk_pin, bit 2 out_comb, bits [5:3] pt_code.
    typedef struct packed {
        logic [CODE_W-1:0] pt_code;
        logic              out_comb;
        logic              clk_pin;
        logic              t_mode;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    typedef enum logic [1:0] {
        CFG_RUN    = 2'd0,
        CFG_SHIFT  = 2'd1,
        CFG_COMMIT = 2'd2
    } cfg_state_e;

endpackage

// File: rtl/mc_cfg_loader.sv
module mc_cfg_loader
    import mc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      prog_en,
    input  logic      sdi,
    output cell_cfg_t cfg
);

    cfg_state_e       state, state_n;
    logic [CFG_W-1:0] shadow;
    cell_cfg_t        active;

    always_comb begin
        state_n = state;
        unique case (state)
            CFG_RUN:    if (prog_en)  state_n = CFG_SHIFT;
            CFG_SHIFT:  if (!prog_en) state_n = CFG_COMMIT;
            CFG_COMMIT: state_n = CFG_RUN;
            default:    state_n = CFG_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CFG_RUN;
        else        state <= state_n;
    end

    // Shift and commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
            active <= '0;
        end else begin
            if (prog_en)
                shadow <= {sdi, shadow[CFG_W-1:1]};
            if (state == CFG_COMMIT)
                active <= cell_cfg_t'(shadow);
        end
    end

    assign cfg = active;

    // R12: the active word never moves outside the commit state
    p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CFG_COMMIT) |=> $stable(active));

    // R12: a shift burst ends in a commit
    p_cfg_commit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CFG_SHIFT && !prog_en) |=> (state == CFG_COMMIT));

endmodule

// File: rtl/mc_sum_term.sv
module mc_sum_term #(
    parameter int N_PT   = 8,
    parameter int MIN_PT = 4,
    parameter int CODE_W = 3
) (
    input  logic [N_PT-1:0]   pt,
    input  logic [CODE_W-1:0] code,
    output logic              sum
);

    logic [N_PT-1:0] en;

    for (genvar i = 0; i < N_PT; i++) begin : g_mask
        if (i < MIN_PT) begin : g_fixed
            assign en[i] = 1'b1;
        end else begin : g_var
            assign en[i] = (int'({1'b0, code}) + MIN_PT) > i;
        end
    end

    assign sum = |(pt & en);

endmodule

// File: rtl/mc_clk_sel.sv
module mc_clk_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sel,
    input  logic src_pt,
    input  logic src_pin,
    output logic fire
);

    logic pt_q, pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pt_q  <= 1'b0;
            pin_q <= 1'b0;
        end else begin
            pt_q  <= src_pt;
            pin_q <= src_pin;
        end
    end

    assign fire = pin_sel ? (src_pin & ~pin_q) : (src_pt & ~pt_q);

    // R5: one event per rising edge while the selection is steady
    p_single_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (!fire || (pin_sel != $past(pin_sel))));

endmodule

// File: rtl/mc_flop.sv
module mc_flop (
    input  logic clk,
    input  logic rst_n,
    input  logic ar,
    input  logic fire,
    input  logic t_mode,
    input  logic d,
    input  logic preset,
    input  logic pl_en,
    input  logic pl_val,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n or posedge ar) begin
        if (!rst_n || ar)      q <= 1'b0;
        else if (pl_en)        q <= pl_val;
        else if (fire) begin
            if (preset)        q <= 1'b1;
            else if (t_mode)   q <= q ^ d;
            else               q <= d;
        end
    end

    p_ar_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ar |-> !q);

    p_preload_r8: assert property (@(posedge clk) disable iff (!rst_n || ar)
        pl_en |=> (q == $past(pl_val)));

    p_preset_r7: assert property (@(posedge clk) disable iff (!rst_n || ar)
        (fire && preset && !pl_en) |=> q);

    p_dmode_r3: assert property (@(posedge clk) disable iff (!rst_n || ar)
        (fire && !preset && !pl_en && !t_mode) |=> (q == $past(d)));

    p_tmode_r4: assert property (@(posedge clk) disable iff (!rst_n || ar)
        (fire && !preset && !pl_en && t_mode) |=> (q == ($past(q) ^ $past(d))));

    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n || ar)
        (!fire && !pl_en) |=> $stable(q));

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
    import mc_pkg::*;
#(
    parameter int N_PT   = 8,
    parameter int MIN_PT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prog_en,
    input  logic            cfg_sdi,
    input  logic [N_PT-1:0] pt_a,
    input  logic [N_PT-1:0] pt_b,
    input  logic            clk_pt,
    input  logic            clk_pin,
    input  logic            ar_pt,
    input  logic            oe_pt,
    input  logic            sync_preset,
    input  logic            preload_en,
    input  logic            preload_val,
    output logic            fb,
    output logic            pad_data,
    output logic            pad_en
);

    cell_cfg_t cfg;
    logic      sum_a, sum_b, fire, q;

    mc_cfg_loader u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .prog_en (prog_en),
        .sdi     (cfg_sdi),
        .cfg     (cfg)
    );

    mc_sum_term #(.N_PT(N_PT), .MIN_PT(MIN_PT), .CODE_W(CODE_W)) u_sum_a (
        .pt   (pt_a),
        .code (cfg.pt_code),
        .sum  (sum_a)
    );

    mc_sum_term #(.N_PT(N_PT), .MIN_PT(MIN_PT), .CODE_W(CODE_W)) u_sum_b (
        .pt   (pt_b),
        .code (cfg.pt_code),
        .sum  (sum_b)
    );

    mc_clk_sel u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_sel (cfg.clk_pin),
        .src_pt  (clk_pt),
        .src_pin (clk_pin),
        .fire    (fire)
    );

    mc_flop u_ff (
        .clk    (clk),
        .rst_n  (rst_n),
        .ar     (ar_pt),
        .fire   (fire),
        .t_mode (cfg.t_mode),
        .d      (sum_a),
        .preset (sync_preset),
        .pl_en  (preload_en),
        .pl_val (preload_val),
        .q      (q)
    );

    assign fb       = q;
    assign pad_data = cfg.out_comb ? sum_b : q;
    assign pad_en   = oe_pt;

    // R2: with no product term active, the combinational pin stays low
    p_sum_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.out_comb && pt_b == '0) |-> !pad_data);

    // R9: in combinational mode the register is still held across idle cycles
    p_buried_r9: assert property (@(posedge clk) disable iff (!rst_n || ar_pt)
        (cfg.out_comb && !fire && !preload_en) |=> $stable(fb));

endmodule

// File: tb/pld_macrocell_bench.sv
`timescale 1ns/1ps
module pld_macrocell_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_en = 1'b0, cfg_sdi = 1'b0;
    logic [7:0] pt_a = '0, pt_b = '0;
    logic       clk_pt = 1'b0, clk_pin = 1'b0, ar_pt = 1'b0, oe_pt = 1'b0;
    logic       sync_preset = 1'b0, preload_en = 1'b0, preload_val = 1'b0;
    logic       fb, pad_data, pad_en;

    pld_macrocell u_pld_macrocell (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .cfg_sdi(cfg_sdi),
        .pt_a(pt_a), .pt_b(pt_b), .clk_pt(clk_pt), .clk_pin(clk_pin),
        .ar_pt(ar_pt), .oe_pt(oe_pt), .sync_preset(sync_preset),
        .preload_en(preload_en), .preload_val(preload_val),
        .fb(fb), .pad_data(pad_data), .pad_en(pad_en)
    );

    always #2 clk = ~clk;

    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;
    logic q_m = 1'b0, ptq_m = 1'b0, pinq_m = 1'b0;
    logic [5:0] cfg_m = '0;

    function automatic logic sum_m(logic [7:0] pt, logic [2:0] code);
        int n = 4 + ((code > 3'd4) ? 4 : int'(code));
        logic s = 1'b0;
        for (int i = 0; i < n; i++) s |= pt[i];
        return s;
    endfunction

    function automatic logic [5:0] mkcfg(logic t, logic pin, logic comb, logic [2:0] code);
        return {code, comb, pin, t};
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // Inputs are already set (1 ns after a rising edge); compare at the falling edge,
    // then advance the model across the next rising edge.
    task automatic step(string tag);
        logic ev, sa, qn;
        if (ar_pt) q_m = 1'b0;
        @(negedge clk);
        chk(tag, "R9 fb", fb, q_m);
        chk(tag, "R10 pad_data", pad_data, cfg_m[2] ? sum_m(pt_b, cfg_m[5:3]) : q_m);
        chk(tag, "R11 pad_en", pad_en, oe_pt);
        ev = cfg_m[1] ? (clk_pin & ~pinq_m) : (clk_pt & ~ptq_m);
        sa = sum_m(pt_a, cfg_m[5:3]);
        if (ar_pt)           qn = 1'b0;
        else if (preload_en) qn = preload_val;
        else if (ev)         qn = sync_preset ? 1'b1 : (cfg_m[0] ? (q_m ^ sa) : sa);
        else                 qn = q_m;
        @(posedge clk);
        #1;
        q_m = qn; ptq_m = clk_pt; pinq_m = clk_pin;
    endtask

    task automatic load_cfg(logic [5:0] w, string tag);
        prog_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            cfg_sdi = w[i];
            step(tag);
        end
        prog_en = 1'b0;
        step(tag);   // SHIFT -> COMMIT, old word still active (R12)
        step(tag);   // commit edge
        cfg_m = w;
    endtask

    task automatic pulse(logic pin, string tag);
        if (pin) clk_pin = 1'b1; else clk_pt = 1'b1;
        step(tag);
        clk_pin = 1'b0; clk_pt = 1'b0;
        step(tag);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R13: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk("R1", "fb after reset", fb, 1'b0);
        chk("R1", "pad_data after reset", pad_data, 1'b0);
        step("R1 idle");
        // R1 R2: default code 0, term 4 excluded, term 3 included
        pt_a = 8'h10; pulse(1'b0, "R2 code0 term4 ignored");
        pt_a = 8'h08; pulse(1'b0, "R2 code0 term3 used R3");
        chk("R3", "D load", fb, 1'b1);
        preload_en = 1'b1; preload_val = 1'b0; step("R8 preload 0"); preload_en = 1'b0;
        load_cfg(mkcfg(0, 0, 0, 3'd1), "R12 load code1");
        pt_a = 8'h10; pulse(1'b0, "R2 code1 term4");
        chk("R2", "term4 with code1", fb, 1'b1);
        pt_a = 8'h40; pulse(1'b0, "R2 code1 term6 ignored");
        load_cfg(mkcfg(0, 0, 0, 3'd7), "R12 load code7");
        pt_a = 8'h80; pulse(1'b0, "R2 code7 term7");
        chk("R2", "term7 with code7", fb, 1'b1);
        // R12 commit timing: registered -> combinational, sum_b=1, q=0
        preload_en = 1'b1; preload_val = 1'b0; step("R8 clear"); preload_en = 1'b0;
        pt_b = 8'h01;
        load_cfg(mkcfg(0, 0, 1, 3'd0), "R12 commit timing");
        chk("R12", "combinational after commit", pad_data, 1'b1);
        chk("R9", "fb buried while pin combinational", fb, 1'b0);
        // R5: pin clock selected, product-term clock ignored
        load_cfg(mkcfg(0, 1, 0, 3'd0), "R5 select pin");
        pt_a = 8'h01; pulse(1'b0, "R5 pt clock ignored");
        chk("R5", "pt clock ignored", fb, 1'b0);
        pulse(1'b1, "R5 pin clock");
        chk("R5", "pin clock loads", fb, 1'b1);
        // R4: T mode
        load_cfg(mkcfg(1, 0, 0, 3'd0), "R4 T mode");
        pulse(1'b0, "R4 toggle"); chk("R4", "toggle to 0", fb, 1'b0);
        pulse(1'b0, "R4 toggle"); chk("R4", "toggle to 1", fb, 1'b1);
        pt_a = 8'h00; pulse(1'b0, "R4 hold"); chk("R4", "no toggle", fb, 1'b1);
        // R13: inputs move without an event
        pt_a = 8'hFF; step("R13 hold"); step("R13 hold");
        chk("R13", "held", fb, 1'b1);
        // R7 preset in D mode with sum 0
        load_cfg(mkcfg(0, 0, 0, 3'd0), "R7 D mode");
        pt_a = 8'h00; preload_en = 1'b1; preload_val = 1'b0; step("R8"); preload_en = 1'b0;
        sync_preset = 1'b1; pulse(1'b0, "R7 preset"); sync_preset = 1'b0;
        chk("R7", "preset loads 1", fb, 1'b1);
        // R8 preload beats preset at an event
        sync_preset = 1'b1; preload_en = 1'b1; preload_val = 1'b0; clk_pt = 1'b1;
        step("R8 over preset");
        chk("R8", "preload wins", fb, 1'b0);
        clk_pt = 1'b0; preload_en = 1'b0; step("R8");
        // R6 async reset beats everything
        preload_en = 1'b1; preload_val = 1'b1; step("R8 set");
        clk_pt = 1'b1; ar_pt = 1'b1; step("R6 over all");
        chk("R6", "async clear", fb, 1'b0);
        ar_pt = 1'b0; clk_pt = 1'b0; preload_en = 1'b0; sync_preset = 1'b0; step("R6 release");
        // R1: reset mid-run clears register and configuration
        preload_en = 1'b1; preload_val = 1'b1; step("R1 prep"); preload_en = 1'b0;
        load_cfg(mkcfg(1, 1, 1, 3'd3), "R1 prep cfg");
        rst_n = 1'b0; @(negedge clk);
        chk("R1", "fb in reset", fb, 1'b0);
        @(posedge clk); #1 rst_n = 1'b1;
        q_m = 1'b0; ptq_m = 1'b0; pinq_m = 1'b0; cfg_m = '0;
        pt_b = 8'hFF; step("R1 cfg cleared");
        chk("R1", "registered pin after reset", pad_data, 1'b0);
        // Random epochs
        for (int e = 0; e < 8; e++) begin
            ar_pt = 1'b0; preload_en = 1'b0;
            load_cfg(6'($urandom), "R12 random load");
            for (int c = 0; c < 300; c++) begin
                pt_a        = 8'($urandom);
                pt_b        = 8'($urandom);
                clk_pt      = 1'($urandom);
                clk_pin     = 1'($urandom);
                oe_pt       = 1'($urandom);
                sync_preset = ($urandom % 4) == 0;
                ar_pt       = ($urandom % 16) == 0;
                preload_en  = ($urandom % 12) == 0;
                preload_val = 1'($urandom);
                step("R3 R4 R7 random");
            end
        end
        finish_run();
    end

endmodule